// File: doc/BRIEF.md
# Converter Protection Fault Manager

This block supervises a synchronous step-down converter. It decides, every clock, whether the power stage may switch normally, must restart its soft-start ramp, must hold the low-side switch on to clamp an overshoot, or must stay off until it is cleared. Its inputs are digital: single-bit comparator results from the analog front end, a busy flag from the soft-start sequencer, and two words from the over-current sample-and-hold. These words are the sensed low-side switch voltage and the sampled trip set-point, both in 10 mV steps.

An over-current event is handled differently the first time and the second time. The first event stops the high side and asks for a fresh soft-start. The second event latches the converter off with both gates low. Feedback under-voltage latches off at once. Feedback over-voltage does not latch: the high side is held off and the low side is forced on until feedback falls back below the lower, hysteretic threshold. Pulling the compensation node low disables the converter. Releasing it clears the latch and the event count and starts again.

Top module: `fault_supervisor`

## Requirements
- R1: Every comparator bit (`fb_uv`, `fb_ov_rise`, `fb_ov_clear`, `comp_disable`) and the internal over-current trip pass through a two-flop synchronizer. A level presented before clock edge k changes the outputs after edge k+2 and not earlier.
- R2: While running, the first over-current event drops `hs_en` and raises `restart_req` for exactly one cycle. Normal switching (`hs_en`=1) then resumes on the next cycle.
- R3: The over-current event that brings the count to OCP_LIMIT (default 2) latches the block off. `latched_off` goes to 1 and `hs_en` and `ls_force` go to 0. This holds until a disable or a reset.
- R4: An over-current trip is raised when `ls_sense` > 2 × S, where S is the effective set-point. S is `ocset_code` when `ocset_valid`=1 and `ocset_code` ≤ SETP_MAX (default 30, i.e. 0.3 V). Otherwise S is SETP_MAX, which gives a 0.6 V trip. A sense value equal to 2 × S does not trip.
- R5: `fb_uv` latches the block off while running, but only while `ss_busy`=0. While the soft-start ramp is busy, `fb_uv` is ignored and switching continues.
- R6: `fb_ov_rise` while running gives `hs_en`=0 and `ls_force`=1. This clamp holds until `fb_ov_clear`=1. The block then returns to switching without a restart request.
- R7: `comp_disable` forces `hs_en`, `ls_force` and `latched_off` to 0 and clears the latch and the event count. After release, `restart_req` pulses once and switching resumes.
- R8: During reset all outputs are 0. After reset is released, `restart_req` is 1 in the first cycle, followed by normal switching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ls_sense | input | SENSE_W | Sensed low-side switch voltage, 10 mV per step |
| ocset_code | input | SETP_W | Sampled over-current set-point, 10 mV per step |
| ocset_valid | input | 1 | Set-point sample is present |
| fb_uv | input | 1 | Feedback below half the reference |
| fb_ov_rise | input | 1 | Feedback above 120 % of the reference |
| fb_ov_clear | input | 1 | Feedback below the falling over-voltage threshold |
| comp_disable | input | 1 | Compensation node pulled below the disable level |
| ss_busy | input | 1 | Soft-start ramp in progress |
| restart_req | output | 1 | One-cycle request for a new soft-start |
| hs_en | output | 1 | High-side switching allowed |
| ls_force | output | 1 | Hold the low-side switch on |
| latched_off | output | 1 | Latched shutdown, both gates off |

## Verification
On every cycle the assertions check the following. The two gate commands are never active together. A latch persists until a disable arrives and always keeps the gates low. A restart request is a single-cycle pulse. A synchronized disable clears switching and the latch on the next edge. Other properties need chosen stimulus and are shown only by the bench scenarios: the exact trip boundary for every set-point code, the default applied to missing or oversized set-points, the three-edge latency, the first-restart/second-latch count, masking of under-voltage during soft-start, and the hysteretic exit from the over-voltage clamp.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  typedef enum logic [2:0] {
    FS_OFF,
    FS_START,
    FS_RUN,
    FS_CLAMP,
    FS_LATCH
  } fs_state_e;
endpackage

// File: rtl/fsup_sync.sv
module fsup_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/fsup_ocp_cmp.sv
module fsup_ocp_cmp #(
  parameter int SENSE_W  = 7,
  parameter int SETP_W   = 6,
  parameter int SETP_MAX = 30
) (
  input  logic [SENSE_W-1:0] sense,
  input  logic [SETP_W-1:0]  setp,
  input  logic               setp_ok,
  output logic               trip
);
  localparam int DBL_W = SETP_W + 1;
  localparam int CMP_W = (SENSE_W > DBL_W) ? SENSE_W : DBL_W;

  logic [SETP_W-1:0] eff;
  logic [DBL_W-1:0]  dbl;

  always_comb begin
    if (setp_ok && (setp <= SETP_W'(SETP_MAX)))
      eff = setp;
    else
      eff = SETP_W'(SETP_MAX);
    dbl  = {eff, 1'b0};
    trip = CMP_W'(sense) > CMP_W'(dbl);
  end
endmodule

// File: rtl/fsup_fsm.sv
module fsup_fsm
  import fsup_pkg::*;
#(
  parameter int OCP_LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ocp,
  input  logic uv,
  input  logic ov_hi,
  input  logic ov_clr,
  input  logic dis,
  input  logic ss_busy,
  output logic restart_req,
  output logic hs_en,
  output logic ls_force,
  output logic latched_off
);
  localparam int CNT_W = $clog2(OCP_LIMIT + 1);

  fs_state_e st, st_nxt;
  logic [CNT_W-1:0] ev_cnt, ev_cnt_nxt;

  always_comb begin
    st_nxt     = st;
    ev_cnt_nxt = ev_cnt;
    if (dis) begin
      st_nxt     = FS_OFF;
      ev_cnt_nxt = '0;
    end else begin
      case (st)
        FS_OFF:   st_nxt = FS_START;
        FS_START: st_nxt = FS_RUN;
        FS_RUN: begin
          if (uv && !ss_busy) begin
            st_nxt = FS_LATCH;
          end else if (ocp) begin
            if (ev_cnt == CNT_W'(OCP_LIMIT - 1)) begin
              st_nxt = FS_LATCH;
            end else begin
              st_nxt     = FS_START;
              ev_cnt_nxt = ev_cnt + 1'b1;
            end
          end else if (ov_hi) begin
            st_nxt = FS_CLAMP;
          end
        end
        FS_CLAMP: if (ov_clr) st_nxt = FS_RUN;
        FS_LATCH: st_nxt = FS_LATCH;
        default:  st_nxt = FS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= FS_OFF;
      ev_cnt <= '0;
    end else begin
      st     <= st_nxt;
      ev_cnt <= ev_cnt_nxt;
    end
  end

  assign restart_req = (st == FS_START);
  assign hs_en       = (st == FS_RUN);
  assign ls_force    = (st == FS_CLAMP);
  assign latched_off = (st == FS_LATCH);
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor #(
  parameter int SENSE_W   = 7,
  parameter int SETP_W    = 6,
  parameter int SETP_MAX  = 30,
  parameter int OCP_LIMIT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SENSE_W-1:0] ls_sense,
  input  logic [SETP_W-1:0]  ocset_code,
  input  logic               ocset_valid,
  input  logic               fb_uv,
  input  logic               fb_ov_rise,
  input  logic               fb_ov_clear,
  input  logic               comp_disable,
  input  logic               ss_busy,
  output logic               restart_req,
  output logic               hs_en,
  output logic               ls_force,
  output logic               latched_off
);
  localparam int NSYNC = 5;

  logic             ocp_raw;
  logic [NSYNC-1:0] raw_bits;
  logic [NSYNC-1:0] syn_bits;
  logic             ocp_s, uv_s, ovh_s, ovc_s, dis_s;

  fsup_ocp_cmp #(
    .SENSE_W (SENSE_W),
    .SETP_W  (SETP_W),
    .SETP_MAX(SETP_MAX)
  ) u_cmp (
    .sense  (ls_sense),
    .setp   (ocset_code),
    .setp_ok(ocset_valid),
    .trip   (ocp_raw)
  );

  assign raw_bits = {comp_disable, fb_ov_clear, fb_ov_rise, fb_uv, ocp_raw};

  fsup_sync #(.W(NSYNC)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_bits),
    .q    (syn_bits)
  );

  assign {dis_s, ovc_s, ovh_s, uv_s, ocp_s} = syn_bits;

  fsup_fsm #(.OCP_LIMIT(OCP_LIMIT)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .ocp        (ocp_s),
    .uv         (uv_s),
    .ov_hi      (ovh_s),
    .ov_clr     (ovc_s),
    .dis        (dis_s),
    .ss_busy    (ss_busy),
    .restart_req(restart_req),
    .hs_en      (hs_en),
    .ls_force   (ls_force),
    .latched_off(latched_off)
  );
endmodule

// File: rtl/fsup_checker.sv
module fsup_checker (
  input logic clk,
  input logic rst_n,
  input logic dis_s,
  input logic restart_req,
  input logic hs_en,
  input logic ls_force,
  input logic latched_off
);
  p_gates_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ls_force |-> !hs_en);

  p_latch_gates_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    latched_off |-> (!hs_en && !ls_force));

  p_latch_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_off && !dis_s) |=> latched_off);

  p_restart_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |=> !restart_req);

  p_disable_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dis_s |=> (!hs_en && !latched_off && !ls_force));
endmodule

bind fault_supervisor fsup_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dis_s      (dis_s),
  .restart_req(restart_req),
  .hs_en      (hs_en),
  .ls_force   (ls_force),
  .latched_off(latched_off)
);

// File: tb/test_fault_supervisor.sv
module test_fault_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int SMAX = 30;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [6:0] ls_sense = '0;
  logic [5:0] ocset_code = '0;
  logic       ocset_valid = 0;
  logic       fb_uv = 0, fb_ov_rise = 0, fb_ov_clear = 1, comp_disable = 0, ss_busy = 0;
  logic       restart_req, hs_en, ls_force, latched_off;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_supervisor i_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .ls_sense(ls_sense), .ocset_code(ocset_code),
    .ocset_valid(ocset_valid), .fb_uv(fb_uv), .fb_ov_rise(fb_ov_rise),
    .fb_ov_clear(fb_ov_clear), .comp_disable(comp_disable), .ss_busy(ss_busy),
    .restart_req(restart_req), .hs_en(hs_en), .ls_force(ls_force),
    .latched_off(latched_off));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int outs();
    return {28'd0, restart_req, hs_en, ls_force, latched_off};
  endfunction

  // expected output vector {restart_req, hs_en, ls_force, latched_off}
  task automatic chk(input string req, input int exp);
    n_run++;
    if (outs() !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, outs()[3:0], exp[3:0], $time);
    end
  endtask

  localparam int O_RST = 4'b1000, O_RUN = 4'b0100, O_CLP = 4'b0010, O_LAT = 4'b0001, O_OFF = 4'b0000;

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    step(2);
    chk("R8 reset", O_OFF);
    rst_n = 1;
    step(1);
    chk("R8 restart after reset", O_RST);
    step(1);
    chk("R8 run after restart", O_RUN);
  endtask

  task automatic pulse_sense(input int v);
    ls_sense = 7'(v);
    step(1);
    ls_sense = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R4 sweep over every set-point code and validity; R1, R2, R3 on each
    for (int c = 0; c < 64; c++) begin
      for (int v = 0; v < 2; v++) begin
        int eff, thr;
        eff = (v == 1 && c <= SMAX) ? c : SMAX;
        thr = 2 * eff;
        ocset_code = 6'(c); ocset_valid = v[0];
        do_reset();
        pulse_sense(thr);
        step(2);
        chk("R4 equal to twice set-point no trip", O_RUN);
        pulse_sense(thr + 1);
        step(1);
        chk("R1 no action before third edge", O_RUN);
        step(1);
        chk("R2 first over-current restarts", O_RST);
        step(1);
        chk("R2 resumes after restart", O_RUN);
        pulse_sense(thr + 1);
        step(2);
        chk("R3 second over-current latches", O_LAT);
      end
    end

    // R3 latch persists; R7 disable clears it and count
    ocset_valid = 1; ocset_code = 6'd10;
    step(20);
    chk("R3 latch holds", O_LAT);
    comp_disable = 1;
    step(3);
    chk("R7 disable clears latch", O_OFF);
    step(5);
    chk("R7 stays off while disabled", O_OFF);
    comp_disable = 0;
    step(3);
    chk("R7 restart on release", O_RST);
    step(1);
    chk("R7 run after release", O_RUN);
    pulse_sense(21);
    step(2);
    chk("R7 count cleared so first event restarts", O_RST);
    step(1);

    // R7 disable during clamp
    fb_ov_rise = 1; fb_ov_clear = 0;
    step(3);
    chk("R6 clamp entered", O_CLP);
    comp_disable = 1;
    step(3);
    chk("R7 disable overrides clamp", O_OFF);
    fb_ov_rise = 0; fb_ov_clear = 1; comp_disable = 0;
    step(4);
    chk("R7 run after second release", O_RUN);

    // R6 hysteretic clamp
    do_reset();
    fb_ov_rise = 1; fb_ov_clear = 0;
    step(3);
    chk("R6 over-voltage forces low side", O_CLP);
    fb_ov_rise = 0;
    step(6);
    chk("R6 clamp holds inside hysteresis band", O_CLP);
    fb_ov_clear = 1;
    step(3);
    chk("R6 resume without restart", O_RUN);

    // R5 under-voltage masked by soft-start, then latches
    do_reset();
    ss_busy = 1; fb_uv = 1;
    step(8);
    chk("R5 under-voltage masked during soft-start", O_RUN);
    ss_busy = 0;
    step(1);
    chk("R5 under-voltage latches", O_LAT);
    fb_uv = 0;
    step(10);
    chk("R5 latch holds after recovery", O_LAT);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule